// File: doc/BRIEF.md
# Set-Associative Translation Cache

This block caches translations from virtual pages to physical pages for three page sizes: 4 KiB, 64 KiB and 1 MiB. It holds 64 sets of 8 ways each. Every page size is indexed by the same field, the low six bits of the 4 KiB page number (virtual address bits 17:12). A large page can therefore be cached in any of several sets, and the set it lands in is chosen by the address that caused the fill. A lookup that reaches a different set of the same large page misses, and the walker refills it there.

A combinational lookup port returns a hit flag, the physical address and the page size code. A fill port accepts one translation per cycle from the page walker. A fill flagged as a fault is never stored. Two maintenance strobes are provided. One invalidates every entry. The other takes one 4 KiB-aligned virtual address and clears, in the single set that the address selects, every valid entry whose tag matches under that entry's own size mask. Fully removing a 1 MiB page therefore takes one address-based flush for each of the 64 sets, and a 64 KiB page takes one for each of its 16 sets. Fills and flushes take effect at the next clock edge.

Top module: `xlat_cache`

## Requirements
- R1: After reset, no entry is valid and every lookup reports a miss (`lkHit` = 0, `lkPa` = 0).
- R2: Size code 2'b00 means 4 KiB. After a 4 KiB fill, a lookup in the same page hits with `lkSize` = 2'b00 and `lkPa` = {stored page bits 31:12, lookup va 11:0}. A lookup in the same set with other va bits 31:12 misses. A hit never reports size 2'b11.
- R3: Size code 2'b01 means 64 KiB. A lookup whose va selects the filled set and matches va bits 31:16 hits, and `lkPa` = {pa 31:16, va 15:0}. A lookup in the same 64 KiB page but in another set (different va bits 17:12) misses.
- R4: Size code 2'b10 means 1 MiB. A lookup that selects the filled set and matches va bits 31:20 hits, including one that differs in va bits 19:18, and `lkPa` = {pa 31:20, va 19:0}.
- R5: A fill writes the lowest-numbered invalid way of its set, and the set's replacement pointer does not move.
- R6: When every way of a set is valid, a fill replaces the way named by that set's round-robin pointer, which starts at way 0 after reset and then advances by one with wrap. Each set has its own pointer.
- R7: `flushAll` invalidates every entry at the next edge.
- R8: An address flush clears only those entries of the set selected by `flushVa[17:12]` whose tag matches `flushVa` under the entry's size mask. `flushVa[11:0]` is ignored, and entries in other sets or with other tags stay valid.
- R9: A fill in the same cycle as either flush strobe is dropped.
- R10: A fill with `fillFault` = 1, or with size code 2'b11, stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkVa | input | VA_W | Lookup virtual address |
| lkHit | output | 1 | Lookup hit |
| lkPa | output | PA_W | Translated physical address (0 on miss) |
| lkSize | output | 2 | Page size code of the hitting entry |
| fillValid | input | 1 | Fill strobe from the walker |
| fillFault | input | 1 | Fill result is a fault; do not cache |
| fillSize | input | 2 | Fill page size code |
| fillVa | input | VA_W | Virtual address that triggered the walk |
| fillPa | input | PA_W | Physical page base |
| flushAll | input | 1 | Invalidate every entry |
| flushAddrValid | input | 1 | Address flush strobe |
| flushVa | input | VA_W | Address for the address flush |

## Verification
Lookups are run against entries of each of the three sizes. Each size is probed with addresses that differ only in offset bits, in bits between the index and the size boundary, and in index bits, so a wrong size mask or a wrong offset merge is caught. Replacement is tested by filling nine and ten entries into one full set, freeing one way with an address flush between fills, and then filling a second set. This separates invalid-first selection from a pointer that is shared between sets or that advances at the wrong time. Address flushes are aimed at a 1 MiB page that is cached in two sets, alongside a 4 KiB entry in the same set, which shows whether only the indexed set and only the masked tag are affected.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

  // Page size codes as seen on fill and lookup ports.
  localparam logic [1:0] PG_4K   = 2'b00;
  localparam logic [1:0] PG_64K  = 2'b01;
  localparam logic [1:0] PG_1M   = 2'b10;
  localparam logic [1:0] PG_BAD  = 2'b11;

  // Address bits below the 4 KiB page number.
  localparam int BASE_SHIFT    = 12;
  // Extra offset bits of the larger pages, relative to 4 KiB.
  localparam int LARGE_SHIFT   = 4;
  localparam int SECTION_SHIFT = 8;

  // Strobes from control to datapath.
  typedef struct packed {
    logic doFill;
    logic doFlushAll;
    logic doFlushAddr;
  } cacheCmd_t;

  // Number of page-number bits that a size treats as offset.
  function automatic int sizeShift(input logic [1:0] sz);
    case (sz)
      PG_64K:  return LARGE_SHIFT;
      PG_1M:   return SECTION_SHIFT;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/xlat_cache_ctrl.sv
module xlat_cache_ctrl
  import xlat_cache_pkg::*;
#(
  parameter int SETS = 64,
  parameter int WAYS = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillValid,
  input  logic             fillFault,
  input  logic [1:0]       fillSize,
  input  logic [SET_W-1:0] fillIdx,
  input  logic             flushAll,
  input  logic             flushAddrValid,
  input  logic [WAYS-1:0]  fillSetValid,
  output cacheCmd_t        cmd,
  output logic [WAYS-1:0]  wayOh
);

  logic [WAY_W-1:0] rrPtr [SETS];
  logic             freeFound;
  logic [WAY_W-1:0] freeWay;
  logic [WAY_W-1:0] victimWay;

  // Lowest-numbered invalid way of the fill set.
  always_comb begin
    freeFound = 1'b0;
    freeWay   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!fillSetValid[w] && !freeFound) begin
        freeFound = 1'b1;
        freeWay   = WAY_W'(w);
      end
    end
    victimWay = freeFound ? freeWay : rrPtr[fillIdx];
    wayOh     = '0;
    wayOh[victimWay] = 1'b1;
  end

  // Flushes win over a fill in the same cycle; faults are never cached.
  always_comb begin
    cmd.doFlushAll  = flushAll;
    cmd.doFlushAddr = flushAddrValid && !flushAll;
    cmd.doFill      = fillValid && !fillFault && (fillSize != PG_BAD)
                      && !flushAll && !flushAddrValid;
  end

  // Per-set round-robin pointer, moved only when a full set is refilled.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
    end else if (cmd.doFill && !freeFound) begin
      if (rrPtr[fillIdx] == WAY_W'(WAYS - 1)) rrPtr[fillIdx] <= '0;
      else                                   rrPtr[fillIdx] <= rrPtr[fillIdx] + 1'b1;
    end
  end

  // R10: a faulting or badly sized fill never produces a write strobe.
  p_no_fault_fill_r10: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && (fillFault || fillSize == PG_BAD)) |-> !cmd.doFill);

  // R5/R6: exactly one way is chosen whenever a write happens.
  p_one_victim_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doFill |-> ($countones(wayOh) == 1));

endmodule

// File: rtl/xlat_cache_dp.sv
module xlat_cache_dp
  import xlat_cache_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int SETS = 64,
  parameter int WAYS = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int VPN_W = VA_W - BASE_SHIFT,
  localparam int PPN_W = PA_W - BASE_SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  cacheCmd_t        cmd,
  input  logic [WAYS-1:0]  wayOh,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic [1:0]       fillSize,
  input  logic [VPN_W-1:0] flushVpn,
  input  logic [VA_W-1:0]  lkVa,
  output logic [WAYS-1:0]  fillSetValid,
  output logic             lkHit,
  output logic [PA_W-1:0]  lkPa,
  output logic [1:0]       lkSize
);

  logic [WAYS-1:0]  validQ [SETS];
  logic [VPN_W-1:0] tagQ   [SETS][WAYS];
  logic [PPN_W-1:0] ppnQ   [SETS][WAYS];
  logic [1:0]       sizeQ  [SETS][WAYS];

  logic [SET_W-1:0] fillIdx, flIdx, lkIdx;
  logic [VPN_W-1:0] lkVpn;
  logic [WAYS-1:0]  flushMatch;

  assign fillIdx = fillVpn[SET_W-1:0];
  assign flIdx   = flushVpn[SET_W-1:0];
  assign lkVpn   = lkVa[VA_W-1:BASE_SHIFT];
  assign lkIdx   = lkVpn[SET_W-1:0];
  assign fillSetValid = validQ[fillIdx];

  // Tag compare that ignores the page-number bits inside the entry's page.
  function automatic logic tagMatch(input logic [VPN_W-1:0] a,
                                    input logic [VPN_W-1:0] b,
                                    input logic [1:0]       sz);
    logic [VPN_W-1:0] m;
    m = {VPN_W{1'b1}} << sizeShift(sz);
    return ((a ^ b) & m) == '0;
  endfunction

  // Address flush: per-way compare within the indexed set.
  for (genvar w = 0; w < WAYS; w++) begin : g_flushCmp
    assign flushMatch[w] = validQ[flIdx][w]
                           && tagMatch(tagQ[flIdx][w], flushVpn, sizeQ[flIdx][w]);
  end

  // Valid bits: flush-all, then address flush, then fill.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (cmd.doFlushAll) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (cmd.doFlushAddr) begin
      validQ[flIdx] <= validQ[flIdx] & ~flushMatch;
    end else if (cmd.doFill) begin
      validQ[fillIdx] <= validQ[fillIdx] | wayOh;
    end
  end

  // Entry payload, written only on an accepted fill.
  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (cmd.doFill && wayOh[w]) begin
        tagQ[fillIdx][w]  <= fillVpn;
        ppnQ[fillIdx][w]  <= fillPpn;
        sizeQ[fillIdx][w] <= fillSize;
      end
    end
  end

  // Lookup: lowest matching way of the indexed set.
  logic             hitSel;
  logic [PPN_W-1:0] ppnSel;
  logic [1:0]       sizeSel;
  logic [PA_W-1:0]  baseMask;
  logic [PA_W-1:0]  vaExt;

  always_comb begin
    hitSel  = 1'b0;
    ppnSel  = '0;
    sizeSel = PG_4K;
    for (int w = 0; w < WAYS; w++) begin
      if (!hitSel && validQ[lkIdx][w]
          && tagMatch(tagQ[lkIdx][w], lkVpn, sizeQ[lkIdx][w])) begin
        hitSel  = 1'b1;
        ppnSel  = ppnQ[lkIdx][w];
        sizeSel = sizeQ[lkIdx][w];
      end
    end
    baseMask = {PA_W{1'b1}} << (BASE_SHIFT + sizeShift(sizeSel));
    vaExt    = PA_W'(lkVa);
    lkHit    = hitSel;
    lkSize   = sizeSel;
    lkPa     = hitSel ? (({ppnSel, {BASE_SHIFT{1'b0}}} & baseMask) | (vaExt & ~baseMask))
                      : '0;
  end

  // R9: an accepted fill never coincides with a flush.
  p_flush_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doFill |-> !(cmd.doFlushAll || cmd.doFlushAddr));

  // R7: nothing hits in the cycle after a flush-all.
  p_flushall_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.doFlushAll) |-> !lkHit);

  // R8: the flushed address misses right after an address flush.
  p_flushaddr_miss_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cmd.doFlushAddr) && (lkVpn == $past(flushVpn))) |-> !lkHit);

  // R2: a hit never reports the reserved size code.
  p_size_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkSize != PG_BAD));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int SETS = 64,
  parameter int WAYS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [VA_W-1:0] lkVa,
  output logic            lkHit,
  output logic [PA_W-1:0] lkPa,
  output logic [1:0]      lkSize,
  input  logic            fillValid,
  input  logic            fillFault,
  input  logic [1:0]      fillSize,
  input  logic [VA_W-1:0] fillVa,
  input  logic [PA_W-1:0] fillPa,
  input  logic            flushAll,
  input  logic            flushAddrValid,
  input  logic [VA_W-1:0] flushVa
);

  localparam int SET_W = $clog2(SETS);
  localparam int VPN_W = VA_W - BASE_SHIFT;
  localparam int PPN_W = PA_W - BASE_SHIFT;

  cacheCmd_t        cmd;
  logic [WAYS-1:0]  wayOh;
  logic [WAYS-1:0]  fillSetValid;
  logic [VPN_W-1:0] fillVpn, flushVpn;
  logic [PPN_W-1:0] fillPpn;
  logic             unusedLowBits;

  assign fillVpn  = fillVa[VA_W-1:BASE_SHIFT];
  assign fillPpn  = fillPa[PA_W-1:BASE_SHIFT];
  assign flushVpn = flushVa[VA_W-1:BASE_SHIFT];
  assign unusedLowBits = ^{fillVa[BASE_SHIFT-1:0], fillPa[BASE_SHIFT-1:0],
                           flushVa[BASE_SHIFT-1:0]};

  xlat_cache_ctrl #(.SETS(SETS), .WAYS(WAYS)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .fillValid      (fillValid),
    .fillFault      (fillFault),
    .fillSize       (fillSize),
    .fillIdx        (fillVpn[SET_W-1:0]),
    .flushAll       (flushAll),
    .flushAddrValid (flushAddrValid),
    .fillSetValid   (fillSetValid),
    .cmd            (cmd),
    .wayOh          (wayOh)
  );

  xlat_cache_dp #(.VA_W(VA_W), .PA_W(PA_W), .SETS(SETS), .WAYS(WAYS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .wayOh        (wayOh),
    .fillVpn      (fillVpn),
    .fillPpn      (fillPpn),
    .fillSize     (fillSize),
    .flushVpn     (flushVpn),
    .lkVa         (lkVa),
    .fillSetValid (fillSetValid),
    .lkHit        (lkHit),
    .lkPa         (lkPa),
    .lkSize       (lkSize)
  );

endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lkVa = '0;
  logic        lkHit;
  logic [31:0] lkPa;
  logic [1:0]  lkSize;
  logic        fillValid = 1'b0, fillFault = 1'b0;
  logic [1:0]  fillSize = 2'b00;
  logic [31:0] fillVa = '0, fillPa = '0;
  logic        flushAll = 1'b0, flushAddrValid = 1'b0;
  logic [31:0] flushVa = '0;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rstN(rstN), .lkVa(lkVa), .lkHit(lkHit), .lkPa(lkPa), .lkSize(lkSize),
    .fillValid(fillValid), .fillFault(fillFault), .fillSize(fillSize),
    .fillVa(fillVa), .fillPa(fillPa), .flushAll(flushAll),
    .flushAddrValid(flushAddrValid), .flushVa(flushVa)
  );

  // One cycle of stimulus, applied between falling edges.
  task automatic step(input logic fv, input logic ff, input logic [1:0] fs,
                      input logic [31:0] fva, input logic [31:0] fpa,
                      input logic fa, input logic fav, input logic [31:0] flv);
    @(negedge clk);
    fillValid = fv; fillFault = ff; fillSize = fs; fillVa = fva; fillPa = fpa;
    flushAll = fa; flushAddrValid = fav; flushVa = flv;
    @(negedge clk);
    fillValid = 1'b0; fillFault = 1'b0; flushAll = 1'b0; flushAddrValid = 1'b0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    step(1'b1, 1'b0, sz, va, pa, 1'b0, 1'b0, '0);
  endtask

  task automatic flushAt(input logic [31:0] va);
    step(1'b0, 1'b0, 2'b00, '0, '0, 1'b0, 1'b1, va);
  endtask

  task automatic look(input string req, input logic [31:0] va, input logic expHit,
                      input logic [31:0] expPa, input logic [1:0] expSz);
    lkVa = va;
    #1;
    nChecks++;
    if (lkHit !== expHit || (expHit && (lkPa !== expPa || lkSize !== expSz))) begin
      nFails++;
      $display("FAIL %s va=%h: hit=%b pa=%h size=%b, expected hit=%b pa=%h size=%b",
               req, va, lkHit, lkPa, lkSize, expHit, expPa, expSz);
    end
  endtask

  function automatic logic [31:0] setVa(input int k, input int s);
    return (32'(k) << 18) | (32'(s) << 12);
  endfunction

  task automatic t_reset;  // R1
    look("R1", 32'h0000_0000, 1'b0, '0, 2'b00);
    look("R1", 32'h1234_5678, 1'b0, '0, 2'b00);
    nChecks++;
    if (lkPa !== 32'h0) begin
      nFails++;
      $display("FAIL R1 pa on miss: %h expected 0", lkPa);
    end
  endtask

  task automatic t_small;  // R2
    fill(32'h1234_5000, 32'h8765_4000, 2'b00);
    look("R2", 32'h1234_5ABC, 1'b1, 32'h8765_4ABC, 2'b00);
    look("R2", 32'h1238_5000, 1'b0, '0, 2'b00);
    look("R2", 32'h1234_6ABC, 1'b0, '0, 2'b00);
  endtask

  task automatic t_large;  // R3
    fill(32'h4003_7000, 32'h9000_0000, 2'b01);
    look("R3", 32'h4003_7ABC, 1'b1, 32'h9000_7ABC, 2'b01);
    look("R3", 32'h4003_2000, 1'b0, '0, 2'b00);
    look("R3", 32'h4007_7000, 1'b0, '0, 2'b00);
  endtask

  task automatic t_section;  // R4
    fill(32'h5550_3000, 32'hA010_0000, 2'b10);
    look("R4", 32'h555C_3DEF, 1'b1, 32'hA01C_3DEF, 2'b10);
    look("R4", 32'h5554_3000, 1'b1, 32'hA014_3000, 2'b10);
    look("R4", 32'h5550_4000, 1'b0, '0, 2'b00);
  endtask

  task automatic t_flushAll;  // R7
    step(1'b0, 1'b0, 2'b00, '0, '0, 1'b1, 1'b0, '0);
    look("R7", 32'h1234_5ABC, 1'b0, '0, 2'b00);
    look("R7", 32'h4003_7ABC, 1'b0, '0, 2'b00);
    look("R7", 32'h555C_3DEF, 1'b0, '0, 2'b00);
  endtask

  task automatic t_replace;  // R5, R6
    for (int k = 1; k <= 8; k++) fill(setVa(k, 9), 32'h7000_0000 | (32'(k) << 12), 2'b00);
    for (int k = 1; k <= 8; k++) look("R5", setVa(k, 9), 1'b1, 32'h7000_0000 | (32'(k) << 12), 2'b00);
    fill(setVa(9, 9), 32'h7000_9000, 2'b00);
    look("R6", setVa(1, 9), 1'b0, '0, 2'b00);
    look("R6", setVa(2, 9), 1'b1, 32'h7000_2000, 2'b00);
    look("R6", setVa(9, 9), 1'b1, 32'h7000_9000, 2'b00);
    fill(setVa(10, 9), 32'h7000_A000, 2'b00);
    look("R6", setVa(2, 9), 1'b0, '0, 2'b00);
    look("R6", setVa(3, 9), 1'b1, 32'h7000_3000, 2'b00);
    // Free way 4, then refill: the free way is used and the pointer stays.
    flushAt(setVa(5, 9));
    fill(setVa(11, 9), 32'h7000_B000, 2'b00);
    look("R5", setVa(3, 9), 1'b1, 32'h7000_3000, 2'b00);
    look("R5", setVa(11, 9), 1'b1, 32'h7000_B000, 2'b00);
    fill(setVa(12, 9), 32'h7000_C000, 2'b00);
    look("R5", setVa(3, 9), 1'b0, '0, 2'b00);
    look("R5", setVa(4, 9), 1'b1, 32'h7000_4000, 2'b00);
    // Another set keeps its own pointer, still at way 0.
    for (int k = 1; k <= 9; k++) fill(setVa(k, 10), 32'h6000_0000 | (32'(k) << 12), 2'b00);
    look("R6", setVa(1, 10), 1'b0, '0, 2'b00);
    look("R6", setVa(2, 10), 1'b1, 32'h6000_2000, 2'b00);
    look("R6", setVa(9, 10), 1'b1, 32'h6000_9000, 2'b00);
  endtask

  task automatic t_flushAddr;  // R8
    step(1'b0, 1'b0, 2'b00, '0, '0, 1'b1, 1'b0, '0);
    fill(32'h6000_0000, 32'hB000_0000, 2'b10);
    fill(32'h6000_1000, 32'hB000_0000, 2'b10);
    fill(32'h0004_0000, 32'hC000_0000, 2'b00);
    flushAt(32'h600C_0000);
    look("R8", 32'h6000_0000, 1'b0, '0, 2'b00);
    look("R8", 32'h0004_0000, 1'b1, 32'hC000_0000, 2'b00);
    look("R8", 32'h6000_1234, 1'b1, 32'hB000_1234, 2'b10);
    flushAt(32'h0004_0FFC);
    look("R8", 32'h0004_0000, 1'b0, '0, 2'b00);
    look("R8", 32'h6000_1234, 1'b1, 32'hB000_1234, 2'b10);
  endtask

  task automatic t_priority;  // R9
    step(1'b1, 1'b0, 2'b00, 32'h7000_2000, 32'hD000_0000, 1'b1, 1'b0, '0);
    look("R9", 32'h7000_2000, 1'b0, '0, 2'b00);
    step(1'b1, 1'b0, 2'b00, 32'h7000_2000, 32'hD000_0000, 1'b0, 1'b1, 32'h0123_4000);
    look("R9", 32'h7000_2000, 1'b0, '0, 2'b00);
    fill(32'h7000_2000, 32'hD000_0000, 2'b00);
    look("R9", 32'h7000_2010, 1'b1, 32'hD000_0010, 2'b00);
  endtask

  task automatic t_fault;  // R10
    step(1'b1, 1'b1, 2'b00, 32'h3000_5000, 32'hE000_0000, 1'b0, 1'b0, '0);
    look("R10", 32'h3000_5000, 1'b0, '0, 2'b00);
    step(1'b1, 1'b0, 2'b11, 32'h3000_6000, 32'hE000_0000, 1'b0, 1'b0, '0);
    look("R10", 32'h3000_6000, 1'b0, '0, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_small;
    t_large;
    t_section;
    t_flushAll;
    t_replace;
    t_flushAddr;
    t_priority;
    t_fault;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule